// File: doc/BRIEF.md
# Serial Converter Host Reader

This block is the host side of a 16-slot serial link to a successive-approximation converter. The converter is clocked only by the host. A request carries a two-bit operation code. The block lowers the chip-select line and toggles the serial clock, which it derives from the system clock by a fixed divider. It samples the returned data line on each serial-clock falling edge and raises chip-select again after a number of falling edges that depends on the operation.

On a conversion, the block takes the N-bit result from the word, puts it on `res_data` and marks it with a one-cycle `res_valid` strobe. The power-down and wake operations use the point at which chip-select rises, counted in falling edges, to put the converter to sleep or bring it back. Their returned data is thrown away.

After every frame the block keeps chip-select high for a quiet interval before it accepts the next request. The `asleep` output shows the power state the host assumes the converter is in.

Top module: `adc_reader`

## Requirements
- R1: While reset is held and just after it, `cs_n`=1, `sclk`=1, `res_valid`=0 and `asleep`=0. Once reset is released, `req_ready`=1.
- R2: `cs_n` falls on the clock after a request is accepted, with `sclk` high. While `cs_n` is low, each `sclk` high or low phase lasts exactly DIV_HALF clocks, and `sclk` is high whenever `cs_n` is high.
- R3: The number of `sclk` falling edges in a frame depends on `req_op`: 0 (convert) gives 16, 1 (short convert) gives 14, 2 (power-down) gives PD_EDGES (legal range 3..9), and 3 (wake) gives 16. `cs_n` and `sclk` both return high DIV_HALF clocks after the last falling edge.
- R4: The data line is sampled just before falling edge k and stored as slot k. The result is slots 3..RES_BITS+2, with slot 3 as the MSB. `res_data` is updated with a one-cycle `res_valid` pulse in the clock in which `cs_n` returns high.
- R5: A short convert (op 1) returns the same result as a full convert of the same sample.
- R6: A power-down frame gives no `res_valid` and sets `asleep` in the clock in which `cs_n` rises. The converter sees chip-select rise after at least 2 and fewer than 10 falling edges.
- R7: A wake frame (op 3) gives no `res_valid` and clears `asleep`.
- R8: A convert or short convert issued while `asleep`=1 runs its full frame, gives no `res_valid` and clears `asleep`. The next convert is valid.
- R9: After `cs_n` rises, it stays high and `req_ready` stays low for at least QUIET_CYC clocks.
- R10: `req_ready` is high only while no frame or quiet interval is in progress. It is low in the clock after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Operation: 0 convert, 1 short convert, 2 power-down, 3 wake |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| cs_n | output | 1 | Chip select to the converter, active low |
| sclk | output | 1 | Serial clock to the converter |
| sdata | input | 1 | Serial data from the converter |
| res_data | output | RES_BITS | Last valid conversion result |
| res_valid | output | 1 | One-cycle strobe for a new result |
| asleep | output | 1 | Host's view of the converter power state |

## Verification
The hardest state to reach is a conversion requested while the converter is assumed asleep. The block must run the whole frame, drop the data and return to the awake state. The bench reaches it with directed sequences such as power-down, power-down, convert, convert, and with random opcode streams that often produce back-to-back power-downs. A behavioural converter model in the bench sends an all-ones pattern whenever it is asleep. The model also decides its own power state from the falling-edge count at which chip-select rises, so the bench can check the chip-select window independently of the `asleep` output.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int SLOTS  = 16;
    localparam int EDGE_W = 5;

    typedef enum logic [1:0] {
        OP_CONV  = 2'd0,
        OP_SHORT = 2'd1,
        OP_PDOWN = 2'd2,
        OP_WAKE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_TAIL,
        ST_QUIET
    } st_e;

    function automatic logic [EDGE_W-1:0] edge_target(input op_e op, input int pd_edges);
        case (op)
            OP_SHORT: return EDGE_W'(SLOTS - 2);
            OP_PDOWN: return EDGE_W'(pd_edges);
            default:  return EDGE_W'(SLOTS);
        endcase
    endfunction

endpackage

// File: rtl/adc_rd_pacer.sv
module adc_rd_pacer #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(DIV_HALF + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == CW'(DIV_HALF - 1));
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int QUIET_CYC = 4,
    parameter int PD_EDGES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic              tick,
    output logic              req_ready,
    output logic              cs_n,
    output logic              sclk,
    output logic              run,
    output logic              clear,
    output logic              fall,
    output logic [EDGE_W-1:0] edge_idx,
    output logic              finish,
    output logic              asleep
);
    localparam int QW = $clog2(QUIET_CYC + 1);

    typedef struct packed {
        st_e              st;
        op_e              op;
        logic             sclk;
        logic             cs_n;
        logic             asleep;
        logic             junk;
        logic [EDGE_W-1:0] edges;
        logic [QW-1:0]    quiet;
    } ctrl_s;

    ctrl_s ctl_d, ctl_q;
    logic [EDGE_W-1:0] nxt_edge;

    always_comb begin
        ctl_d    = ctl_q;
        clear    = 1'b0;
        fall     = 1'b0;
        finish   = 1'b0;
        nxt_edge = ctl_q.edges + 1'b1;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.st    = ST_FRAME;
                    ctl_d.op    = op_e'(req_op);
                    ctl_d.cs_n  = 1'b0;
                    ctl_d.edges = '0;
                    ctl_d.junk  = ctl_q.asleep;
                    clear       = 1'b1;
                end
            end
            ST_FRAME: begin
                if (tick) begin
                    ctl_d.sclk = ~ctl_q.sclk;
                    if (ctl_q.sclk) begin
                        fall        = 1'b1;
                        ctl_d.edges = nxt_edge;
                        if (nxt_edge == edge_target(ctl_q.op, PD_EDGES))
                            ctl_d.st = ST_TAIL;
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    ctl_d.cs_n   = 1'b1;
                    ctl_d.sclk   = 1'b1;
                    ctl_d.st     = ST_QUIET;
                    ctl_d.quiet  = '0;
                    ctl_d.asleep = (ctl_q.op == OP_PDOWN);
                    finish       = (ctl_q.op == OP_CONV || ctl_q.op == OP_SHORT) && !ctl_q.junk;
                end
            end
            ST_QUIET: begin
                ctl_d.quiet = ctl_q.quiet + 1'b1;
                if (ctl_q.quiet == QW'(QUIET_CYC - 1)) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q        <= '0;
            ctl_q.st     <= ST_IDLE;
            ctl_q.op     <= OP_CONV;
            ctl_q.sclk   <= 1'b1;
            ctl_q.cs_n   <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready = (ctl_q.st == ST_IDLE);
    assign run       = (ctl_q.st == ST_FRAME) || (ctl_q.st == ST_TAIL);
    assign cs_n      = ctl_q.cs_n;
    assign sclk      = ctl_q.sclk;
    assign asleep    = ctl_q.asleep;
    assign edge_idx  = nxt_edge;
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture
    import adc_rd_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                fall,
    input  logic [EDGE_W-1:0]   edge_idx,
    input  logic                sdata,
    input  logic                finish,
    output logic [RES_BITS-1:0] res_data,
    output logic                res_valid
);
    localparam int SW      = $clog2(SLOTS);
    localparam int TOP_BIT = SLOTS - 3;

    logic [SLOTS-1:0]    word_d, word_q;
    logic [RES_BITS-1:0] data_d, data_q;
    logic                vld_d, vld_q;

    always_comb begin
        word_d = word_q;
        if (clear)     word_d = '0;
        else if (fall) word_d[SW'(SLOTS - int'(edge_idx))] = sdata;
        data_d = finish ? word_q[TOP_BIT -: RES_BITS] : data_q;
        vld_d  = finish;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            data_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            word_q <= word_d;
            data_q <= data_d;
            vld_q  <= vld_d;
        end
    end

    assign res_data  = data_q;
    assign res_valid = vld_q;
endmodule

// File: rtl/adc_reader.sv
module adc_reader
    import adc_rd_pkg::*;
#(
    parameter int RES_BITS  = 12,
    parameter int DIV_HALF  = 2,
    parameter int QUIET_CYC = 4,
    parameter int PD_EDGES  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    output logic                req_ready,
    output logic                cs_n,
    output logic                sclk,
    input  logic                sdata,
    output logic [RES_BITS-1:0] res_data,
    output logic                res_valid,
    output logic                asleep
);
    logic              tick, run, clear, fall, finish;
    logic [EDGE_W-1:0] edge_idx;

    adc_rd_pacer #(.DIV_HALF(DIV_HALF)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    adc_rd_ctrl #(.QUIET_CYC(QUIET_CYC), .PD_EDGES(PD_EDGES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .tick      (tick),
        .req_ready (req_ready),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .run       (run),
        .clear     (clear),
        .fall      (fall),
        .edge_idx  (edge_idx),
        .finish    (finish),
        .asleep    (asleep)
    );

    adc_rd_capture #(.RES_BITS(RES_BITS)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .fall      (fall),
        .edge_idx  (edge_idx),
        .sdata     (sdata),
        .finish    (finish),
        .res_data  (res_data),
        .res_valid (res_valid)
    );
endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk #(
    parameter int DIV_HALF  = 2,
    parameter int QUIET_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic req_ready,
    input logic res_valid,
    input logic asleep
);
    logic [15:0] hi_cnt_q, ph_cnt_q;
    logic        sclk_prev_q, csn_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt_q    <= 16'(QUIET_CYC);
            ph_cnt_q    <= '0;
            sclk_prev_q <= 1'b1;
            csn_prev_q  <= 1'b1;
        end else begin
            if (!cs_n)                  hi_cnt_q <= '0;
            else if (hi_cnt_q != '1)    hi_cnt_q <= hi_cnt_q + 1'b1;
            if (sclk != sclk_prev_q)    ph_cnt_q <= '0;
            else if (ph_cnt_q != '1)    ph_cnt_q <= ph_cnt_q + 1'b1;
            sclk_prev_q <= sclk;
            csn_prev_q  <= cs_n;
        end
    end

    p_sclk_high_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);
    p_cs_fall_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> sclk);
    p_phase_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((sclk != sclk_prev_q) && !csn_prev_q) |-> (ph_cnt_q >= 16'(DIV_HALF - 1)));
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    p_valid_at_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $rose(cs_n));
    p_sleep_at_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $rose(cs_n));
    p_quiet_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt_q >= 16'(QUIET_CYC)));
    p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> cs_n);
endmodule

bind adc_reader adc_rd_chk #(.DIV_HALF(DIV_HALF), .QUIET_CYC(QUIET_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .req_ready (req_ready),
    .res_valid (res_valid),
    .asleep    (asleep)
);

// File: tb/adc_reader_tb.sv
module adc_reader_tb;
    localparam int N     = 12;
    localparam int DIVH  = 2;
    localparam int QUIET = 4;
    localparam int PDE   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic req_ready, cs_n, sclk, res_valid, asleep;
    logic sdata = 1'b1;
    logic [N-1:0] res_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #10 clk = ~clk;

    adc_reader #(.RES_BITS(N), .DIV_HALF(DIVH), .QUIET_CYC(QUIET), .PD_EDGES(PDE)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_ready(req_ready), .cs_n(cs_n), .sclk(sclk), .sdata(sdata),
        .res_data(res_data), .res_valid(res_valid), .asleep(asleep)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    logic [N-1:0] smp_m = '0;
    logic         m_asleep = 1'b0;
    logic         m_junk = 1'b0;
    int           falls = 0;
    int           slot = 0;

    function automatic logic [15:0] frame_word(input logic [N-1:0] s, input logic junk);
        if (junk) return 16'hFFFF;
        return 16'(s) << (14 - N);
    endfunction

    function automatic logic slot_bit(input int k);
        logic [15:0] w;
        w = frame_word(smp_m, m_junk);
        if (k < 1 || k > 16) return 1'b1;
        return w[16-k];
    endfunction

    always @(negedge cs_n) begin
        m_junk = m_asleep;
        falls  = 0;
        slot   = 1;
        sdata  = slot_bit(1);
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            falls++;
            slot++;
            sdata = slot_bit(slot);
        end
    end

    always @(posedge cs_n) begin
        sdata = 1'b1;
        if (m_asleep) begin
            if (falls >= 10) m_asleep = 1'b0;
        end else if (falls >= 2 && falls < 10) begin
            m_asleep = 1'b1;
        end
    end

    // ---------------- monitors ----------------
    int           vcnt = 0;
    logic [N-1:0] vdata = '0;
    int           hi_run = 1000;
    int           min_gap = 1000;
    int           ph_run = 1000;
    int           min_ph = 1000;
    logic         prev_cs = 1'b1;
    logic         prev_sclk = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (res_valid) begin
                vcnt++;
                vdata = res_data;
            end
            if (cs_n) hi_run++;
            else begin
                if (prev_cs && hi_run < min_gap) min_gap = hi_run;
                hi_run = 0;
            end
            if (sclk != prev_sclk) begin
                if (!prev_cs && ph_run < min_ph) min_ph = ph_run;
                ph_run = 1;
            end else ph_run++;
            prev_cs   = cs_n;
            prev_sclk = sclk;
        end
    end

    // ---------------- operation driver ----------------
    logic exp_sleep = 1'b0;

    task automatic run_op(input logic [1:0] op, input logic [N-1:0] s);
        int v0, tgt;
        logic exp_v;
        smp_m = s;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 ready low after accept", 32'(req_ready), 32'd0);
        check("R2 cs_n low after accept", 32'(cs_n), 32'd0);
        v0 = vcnt;
        while (!cs_n) @(negedge clk);
        @(negedge clk);
        tgt   = (op == 2'd1) ? 14 : (op == 2'd2) ? PDE : 16;
        exp_v = (op == 2'd0 || op == 2'd1) && !exp_sleep;
        check("R3 falling edge count", 32'(falls), 32'(tgt));
        check("R4 R6 R7 R8 valid pulses", 32'(vcnt - v0), exp_v ? 32'd1 : 32'd0);
        if (exp_v) check(op == 2'd1 ? "R5 short result" : "R4 result", 32'(vdata), 32'(s));
        exp_sleep = (op == 2'd2);
        check("R6 R7 R8 asleep flag", 32'(asleep), 32'(exp_sleep));
        check("R6 converter power window", 32'(m_asleep), 32'(exp_sleep));
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        check("R1 cs_n in reset", 32'(cs_n), 32'd1);
        check("R1 sclk in reset", 32'(sclk), 32'd1);
        check("R1 res_valid in reset", 32'(res_valid), 32'd0);
        check("R1 asleep in reset", 32'(asleep), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", 32'(req_ready), 32'd1);
        check("R1 cs_n after reset", 32'(cs_n), 32'd1);

        // directed corner cases
        run_op(2'd0, 12'hFFF);
        run_op(2'd0, 12'h000);
        run_op(2'd0, 12'h801);
        run_op(2'd1, 12'hA5A);
        run_op(2'd1, 12'h001);
        run_op(2'd2, 12'h123);   // power-down R6
        run_op(2'd2, 12'h456);   // repeated power-down stays asleep
        run_op(2'd0, 12'h789);   // convert while asleep R8
        run_op(2'd0, 12'h3C3);   // next convert valid R8
        run_op(2'd3, 12'h111);   // wake while awake R7
        run_op(2'd2, 12'h222);
        run_op(2'd3, 12'h333);   // wake after power-down R7
        run_op(2'd1, 12'h5A5);
        run_op(2'd2, 12'h0F0);
        run_op(2'd1, 12'hF0F);   // short convert while asleep R8
        run_op(2'd1, 12'h0F0);

        // random stream
        for (int i = 0; i < 60; i++) begin
            run_op(2'($urandom % 4), N'($urandom));
        end

        check("R9 minimum quiet gap", 32'(min_gap >= QUIET + 1), 32'd1);
        check("R2 minimum sclk phase", 32'(min_ph), 32'(DIVH));
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule